// File: doc/BRIEF.md
# Transmit Cell Buffer with Bus Integrity Alarms

This block sits between an ATM-layer master and a transmit cell processor. The master pushes 53-octet cells, one octet per accepted transfer, over a UTOPIA-style write bus: write strobe, start-of-cell marker, an 8-bit data word and a parity bit. The block assembles each cell into one slot of a small cell-granular FIFO. It releases a cell to the downstream reader only when the whole cell has arrived. The reader pulls stored cells one octet per strobe, and a start marker flags the first octet of each cell.

Three faults are watched on the write side. The first is a bus parity error on any transfer. The second is an overrun, where a cell starts while every slot is taken. The third is a loss of cell alignment, where the start marker is misplaced or missing. Each fault sets a sticky status bit. A single 8-bit control register holds the status bits, one interrupt enable per fault, a switch that drops cells carrying parity errors, and a self-clearing FIFO flush command. Reading the register clears the status bits. The interrupt output is the OR of every enabled status bit.

Top module: `utx_cell_fifo`

## Requirements
- R1: The FIFO holds up to 4 cells of 53 octets. A cell becomes readable only on the edge that accepts its 53rd octet: `rd_valid` is 1 exactly while at least one complete cell is stored. Cells leave in arrival order, one octet per cycle with `rd_en`=1, and `rd_soc`=1 marks octet 0.
- R2: A transfer (`in_valid`=1) has good parity when the count of ones over `in_data` and `in_par` together is odd. Any other transfer sets the parity status, register bit 2.
- R3: When the drop switch (register bit 7) is 1, a cell in which any octet had bad parity is not stored. When the switch is 0, that cell is stored as received. The switch value at the cell's last octet decides.
- R4: `space_avail` is 1 while fewer than 4 complete cells are stored. A transfer with `in_soc`=1 at a time when `space_avail`=0 sets the overrun status, register bit 1, and its whole cell is dropped.
- R5: A transfer with `in_soc`=1 in the middle of a cell, or with `in_soc`=0 while no cell is open, sets the alignment status, register bit 0. In the first case the partial cell is dropped and a new cell starts with that octet. In the second case the octet is dropped.
- R6: Writing 1 to register bit 6 empties the FIFO and aborts the partial cell on that edge, and the bus transfer of that same cycle is ignored. Bit 6 always reads 0.
- R7: The register reads as {drop switch, 0, parity enable, overrun enable, alignment enable, parity status, overrun status, alignment status}, from bit 7 down to bit 0. A write updates bits 7, 5, 4 and 3 only.
- R8: A cycle with `reg_rd`=1 clears all three status bits on its edge, except that a fault detected in that same cycle leaves its bit set.
- R9: `irq` is 1 exactly when some status bit and its matching enable bit are both 1.
- R10: After reset the FIFO is empty (`rd_valid`=0, `space_avail`=1), the register reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write bus transfer strobe |
| in_soc | input | 1 | Start-of-cell marker for this transfer |
| in_data | input | 8 | Write bus data octet |
| in_par | input | 1 | Odd parity bit for `in_data` |
| space_avail | output | 1 | At least one free cell slot |
| rd_en | input | 1 | Reader takes one octet |
| rd_valid | output | 1 | A complete cell is stored |
| rd_data | output | 8 | Current read octet |
| rd_soc | output | 1 | Current read octet is octet 0 of its cell |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the edge at which the 53rd octet lands. A design that exposed cells early would raise `rd_valid` one octet too soon, and a design with an off-by-one would hold it back a cycle. Overrun is probed by offering a fifth cell to a full FIFO; a faulty design would overwrite the oldest cell or keep part of the new one. The bench misplaces start markers, injects parity faults with the drop switch both on and off, and issues a flush in the middle of a cell. A wrong design would show a stale partial cell, store a corrupted cell, or lose the first octet after resynchronising. It also reads the register in the very cycle a fault occurs, which catches a clear that takes priority over the set.

// File: rtl/utx_pkg.sv
package utx_pkg;

  // Fault pulses from the write side, ordered as status bits 2..0.
  typedef struct packed {
    logic par;
    logic ovr;
    logic aln;
  } utx_evt_t;

  localparam int REG_W = 8;

  // Bit positions inside the control/status register.
  localparam int B_DROP = 7;
  localparam int B_FLSH = 6;
  localparam int B_EN_H = 5;
  localparam int B_EN_L = 3;

endpackage

// File: rtl/utx_parity_chk.sv
module utx_parity_chk #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          par,
  output logic          good
);
  // Odd parity: data bits plus parity bit carry an odd number of ones.
  assign good = ^{data, par};
endmodule

// File: rtl/utx_ctl_reg.sv
module utx_ctl_reg
  import utx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  input  utx_evt_t         evt,
  output logic [REG_W-1:0] reg_rdata,
  output logic             drop_bad,
  output logic             flush,
  output logic             irq
);
  logic       drop_q, drop_d;
  logic [2:0] en_q, en_d;
  logic [2:0] st_q, st_d;
  logic [2:0] evt_v;
  logic       unused_wbits;

  assign evt_v        = evt;
  assign unused_wbits = ^reg_wdata[2:0];

  always_comb begin
    drop_d = drop_q;
    en_d   = en_q;
    st_d   = st_q;
    if (reg_wr) begin
      drop_d = reg_wdata[B_DROP];
      en_d   = reg_wdata[B_EN_H:B_EN_L];
    end
    if (reg_rd) st_d = 3'b000;
    st_d = st_d | evt_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
      en_q   <= 3'b000;
      st_q   <= 3'b000;
    end else begin
      drop_q <= drop_d;
      en_q   <= en_d;
      st_q   <= st_d;
    end
  end

  assign flush     = reg_wr & reg_wdata[B_FLSH];
  assign drop_bad  = drop_q;
  assign reg_rdata = {drop_q, 1'b0, en_q, st_q};
  assign irq       = |(en_q & st_q);

  // R8: a read with no fault in the same cycle leaves all status clear.
  p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (evt_v == 3'b000)) |=> (reg_rdata[2:0] == 3'b000));

  // R8: a fault always survives a simultaneous read.
  p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_v != 3'b000) |=> ((reg_rdata[2:0] & $past(evt_v)) == $past(evt_v)));
endmodule

// File: rtl/utx_cell_store.sv
module utx_cell_store #(
  parameter int DW    = 8,
  parameter int OCT   = 53,
  parameter int SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   wr_en,
  input  logic [$clog2(OCT)-1:0] wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic                   commit,
  input  logic                   rd_en,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_soc,
  output logic                   rd_valid,
  output logic                   space_avail
);
  localparam int IDX_W  = $clog2(OCT);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int DEPTH  = SLOTS * OCT;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [DW-1:0]     mem [DEPTH];
  logic [SLOT_W-1:0] wr_slot_q, wr_slot_d, rd_slot_q, rd_slot_d;
  logic [IDX_W-1:0]  rd_idx_q, rd_idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              step, rd_last, pop;

  function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] s);
    if (s == SLOT_W'(SLOTS - 1)) slot_inc = '0;
    else                         slot_inc = s + SLOT_W'(1);
  endfunction

  assign wr_addr = ADDR_W'(wr_slot_q) * ADDR_W'(OCT) + ADDR_W'(wr_idx);
  assign rd_addr = ADDR_W'(rd_slot_q) * ADDR_W'(OCT) + ADDR_W'(rd_idx_q);

  assign rd_valid    = (cnt_q != '0);
  assign space_avail = (cnt_q < CNT_W'(SLOTS));
  assign step        = rd_en & rd_valid;
  assign rd_last     = (rd_idx_q == IDX_W'(OCT - 1));
  assign pop         = step & rd_last;

  always_comb begin
    cnt_d     = cnt_q;
    wr_slot_d = wr_slot_q;
    rd_slot_d = rd_slot_q;
    rd_idx_d  = rd_idx_q;
    if (flush) begin
      cnt_d     = '0;
      wr_slot_d = '0;
      rd_slot_d = '0;
      rd_idx_d  = '0;
    end else begin
      if (step) begin
        if (rd_last) begin
          rd_idx_d  = '0;
          rd_slot_d = slot_inc(rd_slot_q);
        end else begin
          rd_idx_d = rd_idx_q + IDX_W'(1);
        end
      end
      if (commit) wr_slot_d = slot_inc(wr_slot_q);
      cnt_d = cnt_q + CNT_W'(commit) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      wr_slot_q <= '0;
      rd_slot_q <= '0;
      rd_idx_q  <= '0;
    end else begin
      cnt_q     <= cnt_d;
      wr_slot_q <= wr_slot_d;
      rd_slot_q <= rd_slot_d;
      rd_idx_q  <= rd_idx_d;
    end
  end

  // Storage array: data only, no reset needed.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
  assign rd_soc  = (rd_idx_q == '0);

  // R1: never more complete cells than slots.
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SLOTS));

  // R1: a completed cell is never accepted while every slot is full.
  p_no_commit_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (space_avail || pop));
endmodule

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo
  import utx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CELL_OCTETS = 53,
  parameter int CELL_SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_soc,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_par,
  output logic              space_avail,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_soc,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int IDX_W = $clog2(CELL_OCTETS);
  localparam int LAST  = CELL_OCTETS - 1;

  logic             par_ok, flush, drop_bad, xfer;
  logic             open_q, open_d;
  logic             drop_q, drop_d;
  logic             perr_q, perr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             wr_en, commit, perr_all;
  logic [IDX_W-1:0] wr_idx;
  utx_evt_t         evt;

  utx_parity_chk #(.DW(DATA_W)) u_par (
    .data (in_data),
    .par  (in_par),
    .good (par_ok)
  );

  utx_ctl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .evt       (evt),
    .reg_rdata (reg_rdata),
    .drop_bad  (drop_bad),
    .flush     (flush),
    .irq       (irq)
  );

  utx_cell_store #(
    .DW    (DATA_W),
    .OCT   (CELL_OCTETS),
    .SLOTS (CELL_SLOTS)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (in_data),
    .commit      (commit),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_soc      (rd_soc),
    .rd_valid    (rd_valid),
    .space_avail (space_avail)
  );

  // A transfer in a flush cycle is ignored.
  assign xfer     = in_valid & ~flush;
  assign perr_all = perr_q | ~par_ok;

  always_comb begin
    open_d  = open_q;
    drop_d  = drop_q;
    perr_d  = perr_q;
    idx_d   = idx_q;
    wr_en   = 1'b0;
    wr_idx  = idx_q;
    commit  = 1'b0;
    evt.par = xfer & ~par_ok;
    evt.ovr = xfer & in_soc & ~space_avail;
    evt.aln = xfer & (in_soc ? open_q : ~open_q);
    if (flush) begin
      open_d = 1'b0;
    end else if (xfer && in_soc) begin
      open_d = 1'b1;
      drop_d = ~space_avail;
      perr_d = ~par_ok;
      idx_d  = IDX_W'(1);
      wr_idx = '0;
      wr_en  = space_avail;
    end else if (xfer && open_q) begin
      wr_en  = ~drop_q;
      perr_d = perr_all;
      if (idx_q == IDX_W'(LAST)) begin
        open_d = 1'b0;
        commit = ~drop_q & ~(drop_bad & perr_all);
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      drop_q <= 1'b0;
      perr_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      open_q <= open_d;
      drop_q <= drop_d;
      perr_q <= perr_d;
      idx_q  <= idx_d;
    end
  end

  // R2: a bad-parity transfer raises the parity status.
  p_par_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && !par_ok) |=> reg_rdata[2]);

  // R4: a start with no free slot raises the overrun status.
  p_ovr_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_soc && !flush && !space_avail) |=> reg_rdata[1]);

  // R5: an octet with no open cell raises the alignment status.
  p_aln_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_soc && !flush && !open_q) |=> reg_rdata[0]);

  // R6: a flush leaves the FIFO empty.
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rd_valid && space_avail));
endmodule

// File: tb/utx_cell_fifo_bench.sv
module utx_cell_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_soc, in_par;
  logic [7:0] in_data;
  logic       space_avail, rd_en, rd_valid, rd_soc, irq;
  logic [7:0] rd_data;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;

  int checks   = 0;
  int failures = 0;
  int rd_mode  = 0;
  bit done     = 0;

  always #4 clk = ~clk;  // 125 MHz

  utx_cell_fifo u_utx_cell_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
    .in_data(in_data), .in_par(in_par), .space_avail(space_avail),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_soc(rd_soc),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  logic [7:0] cur[$];
  int         m_cnt, rd_pos, cb;
  bit         m_open, m_drop, m_perr, m_disc, fl, bad;
  bit  [2:0]  m_en, m_st, ev;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); cur.delete();
      m_cnt = 0; rd_pos = 0; m_open = 0; m_drop = 0; m_perr = 0;
      m_disc = 0; m_en = 0; m_st = 0;
    end else begin
      cb = m_cnt;
      ev = 3'b000;
      fl = reg_wr && reg_wdata[6];
      if (fl) begin
        mq.delete(); cur.delete();
        m_cnt = 0; rd_pos = 0; m_open = 0;
      end else if (rd_en && m_cnt > 0) begin
        void'(mq.pop_front());
        rd_pos++;
        if (rd_pos == 53) begin rd_pos = 0; m_cnt--; end
      end
      if (in_valid && !fl) begin
        bad = !(^{in_data, in_par});
        if (bad) ev[2] = 1'b1;
        if (in_soc) begin
          if (m_open) ev[0] = 1'b1;
          if (cb == 4) ev[1] = 1'b1;
          m_drop = (cb == 4);
          m_perr = bad;
          cur.delete();
          cur.push_back(in_data);
          m_open = 1;
        end else if (!m_open) begin
          ev[0] = 1'b1;
        end else begin
          cur.push_back(in_data);
          m_perr = m_perr | bad;
          if (cur.size() == 53) begin
            m_open = 0;
            if (!m_drop && !(m_disc && m_perr)) begin
              foreach (cur[i]) mq.push_back(cur[i]);
              m_cnt++;
            end
          end
        end
      end
      if (reg_rd) m_st = 3'b000;
      m_st = m_st | ev;
      if (reg_wr) begin m_disc = reg_wdata[7]; m_en = reg_wdata[5:3]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle compare against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk(rd_valid == (m_cnt > 0), "R1 rd_valid", rd_valid, m_cnt > 0);
      if (m_cnt > 0) begin
        chk(rd_data == mq[0], "R1 rd_data", rd_data, mq[0]);
        chk(rd_soc == (rd_pos == 0), "R1 rd_soc", rd_soc, rd_pos == 0);
      end
      chk(space_avail == (m_cnt < 4), "R4 space_avail", space_avail, m_cnt < 4);
      chk(reg_rdata == {m_disc, 1'b0, m_en, m_st}, "R7 reg_rdata", reg_rdata,
          {m_disc, 1'b0, m_en, m_st});
      chk(irq == |(m_en & m_st), "R9 irq", irq, |(m_en & m_st));
    end
  end

  // Reader strobe pattern.
  initial begin
    rd_en = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_mode == 0) rd_en = 1'b0;
      else if (rd_mode == 1) rd_en = 1'b1;
      else rd_en = ($urandom % 2) == 1;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [7:0] dat(input int s, input int i);
    return 8'(s * 37 + i * 5 + 3);
  endfunction

  task automatic send_range(input int s, input int first, input int last,
                            input int bad_at, input bit gaps);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      if (gaps) begin
        while (($urandom % 4) == 0) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      in_soc   = (i == 0);
      in_data  = dat(s, i);
      in_par   = (i == bad_at) ? (^dat(s, i)) : ~(^dat(s, i));
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_soc   = 1'b0;
  endtask

  task automatic stray(input bit rd_too);
    @(negedge clk);
    in_valid = 1'b1; in_soc = 1'b0; in_data = 8'h5A; in_par = ~(^8'h5A);
    reg_rd = rd_too;
    @(negedge clk);
    in_valid = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg();
    @(negedge clk);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic drain();
    rd_mode = 1;
    repeat (4 * 53 + 4) @(negedge clk);
    rd_mode = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_soc = 1'b0; in_data = 8'h00; in_par = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R10 reg", reg_rdata, 8'h00);
    chk(rd_valid == 1'b0, "R10 rd_valid", rd_valid, 0);
    chk(space_avail == 1'b1, "R10 space_avail", space_avail, 1);
    chk(irq == 1'b0, "R10 irq", irq, 0);

    wreg(8'h38);
    chk(reg_rdata == 8'h38, "R7 enables", reg_rdata, 8'h38);
    wreg(8'hFF);
    chk(reg_rdata == 8'hB8, "R6 flush bit reads 0", reg_rdata, 8'hB8);
    wreg(8'h38);

    // R1: visibility only after the last octet.
    send_range(1, 0, 51, -1, 0);
    chk(rd_valid == 1'b0, "R1 partial cell hidden", rd_valid, 0);
    send_range(1, 52, 52, -1, 0);
    chk(rd_valid == 1'b1, "R1 full cell visible", rd_valid, 1);
    chk(rd_data == dat(1, 0) && rd_soc, "R1 first octet", rd_data, dat(1, 0));

    // R4: fill to four, then overrun.
    for (int c = 2; c <= 4; c++) send_range(c, 0, 52, -1, c == 3);
    chk(space_avail == 1'b0, "R4 full", space_avail, 0);
    send_range(5, 0, 52, -1, 0);
    chk(reg_rdata == 8'h3A, "R4 overrun status", reg_rdata, 8'h3A);
    chk(irq == 1'b1, "R9 irq on overrun", irq, 1);
    rreg();
    chk(reg_rdata == 8'h38, "R8 clear on read", reg_rdata, 8'h38);
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);
    drain();
    chk(rd_valid == 1'b0, "R1 drained", rd_valid, 0);

    // R2/R3: parity with drop switch off then on.
    send_range(6, 0, 52, 10, 0);
    chk(rd_valid == 1'b1, "R3 kept when switch off", rd_valid, 1);
    chk(reg_rdata == 8'h3C, "R2 parity status", reg_rdata, 8'h3C);
    drain();
    rreg();
    wreg(8'hB8);
    send_range(7, 0, 52, 52, 0);
    chk(rd_valid == 1'b0, "R3 dropped when switch on", rd_valid, 0);
    chk(reg_rdata == 8'hBC, "R2 parity on last octet", reg_rdata, 8'hBC);
    wreg(8'h80);
    chk(irq == 1'b0, "R9 masked", irq, 0);
    chk(reg_rdata == 8'h84, "R7 status kept across write", reg_rdata, 8'h84);
    rreg();

    // R5: misplaced start and stray octet.
    wreg(8'h08);
    send_range(8, 0, 19, -1, 0);
    send_range(9, 0, 52, -1, 0);
    chk(reg_rdata == 8'h09, "R5 mid-cell start", reg_rdata, 8'h09);
    chk(rd_valid && rd_data == dat(9, 0), "R5 resync cell", rd_data, dat(9, 0));
    drain();
    rreg();
    stray(0);
    chk(reg_rdata == 8'h09, "R5 stray octet", reg_rdata, 8'h09);
    chk(rd_valid == 1'b0, "R5 stray not stored", rd_valid, 0);
    rreg();

    // R6: flush mid-cell with stored cells.
    send_range(10, 0, 52, -1, 0);
    send_range(11, 0, 52, -1, 0);
    fork
      send_range(12, 0, 52, -1, 0);
      begin repeat (20) @(negedge clk); wreg(8'h48); end
    join
    chk(rd_valid == 1'b0, "R6 flushed", rd_valid, 0);
    chk(reg_rdata == 8'h09, "R6 tail seen as strays", reg_rdata, 8'h09);
    rreg();
    chk(reg_rdata == 8'h08, "R8 cleared", reg_rdata, 8'h08);
    stray(1);
    chk(reg_rdata == 8'h09, "R8 set wins over read", reg_rdata, 8'h09);

    // Mixed traffic with a random reader.
    wreg(8'hB8);
    rd_mode = 2;
    for (int c = 20; c < 50; c++)
      send_range(c, 0, 52, (c % 7 == 0) ? (c % 53) : -1, 1);
    rd_mode = 1;
    repeat (300) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 final drain", rd_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule